// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block holds the per-channel enable, pending and active state for a small interrupt controller on the processor side. Every request line goes through one shared path, and that path serves both short pulses and lines held at a level. No per-channel setting chooses between the two kinds of line.

A synchronized rising edge makes a channel pending. The channel stays pending until the core takes it. When the core leaves a handler, the block samples the line again. If the line is still high, the channel becomes pending again. This covers a level source whose handler did not clear the cause.

Software uses one write port to:
- set or clear enables;
- set or clear pending bits;
- raise one channel by number.

The block presents the lowest-numbered channel that is enabled, pending and not active. The core replies with an entry acknowledge that names the channel. It signals the end of the handler with an exit strobe. There is no nesting, so at most one channel is active at a time.

Top module: `irq_state_tracker`

## Requirements
- R1: The edge path and the level path are both active on every channel. No input or register selects between them.
- R2: A rising edge on a synchronized line sets the channel's pending bit. The bit stays set after the line falls, until the channel is acknowledged or cleared.
- R3: An entry acknowledge on channel `ack_ch` sets that channel's active bit and clears its pending bit in the same edge. At most one channel is active at a time.
- R4: A rising edge on a channel's line while the channel is active sets its pending bit again. The channel is presented once more after the exit strobe.
- R5: The exit strobe clears the active bit. If the synchronized line of that channel is high at that edge, its pending bit is set. If the line is low, the bit is not set.
- R6: A disabled channel can still become pending and stays pending. It is presented as soon as it is enabled. Clear-enable (op 1) removes it from presentation.
- R7: Set-pending (op 2) sets the pending bit of every channel whose bit in `wr_data` is one. This works with the line low.
- R8: Software trigger (op 4) sets the pending bit of the channel whose number is in the low `CW` bits of `wr_data`.
- R9: `req_o` is high exactly when some channel is pending, enabled and not active. `sel_ch` is the lowest-numbered such channel.
- R10: Clear-pending (op 3) clears the pending bits at the one positions of `wr_data`. If a set event hits the same bit in the same edge, the set wins.
- R11: Request inputs pass through two flops before edge detection. A line raised before edge E0 makes the channel pending at edge E2.
- R12: Reset clears all enable, pending, active and synchronizer state, so `req_o` is low. Zero bits written through set-enable (op 0), clear-enable, set-pending or clear-pending change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NCH | Raw request lines, one per channel |
| wr_en | input | 1 | Write strobe for the software port |
| wr_op | input | 3 | 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 software trigger |
| wr_data | input | NCH | Channel mask, or channel number in the low CW bits for op 4 |
| ack_valid | input | 1 | Entry acknowledge from the core |
| ack_ch | input | CW | Channel being entered |
| exit_strobe | input | 1 | Handler exit from the core |
| sel_ch | output | CW | Lowest-numbered presentable channel |
| req_o | output | 1 | Some channel is presentable |

## Verification
The checker assumes the core never acknowledges entry while another channel is still active. It also assumes that an exit strobe comes only while a handler is active, since the block does not support nesting. The bench pairs every acknowledge with an exit before the next acknowledge, and it acknowledges only the channel shown on `sel_ch`. It keeps the request lines steady for at least three cycles around each exit, so that every sample at an exit has a known value.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  typedef enum logic [2:0] {
    OP_SET_EN   = 3'd0,
    OP_CLR_EN   = 3'd1,
    OP_SET_PEND = 3'd2,
    OP_CLR_PEND = 3'd3,
    OP_SW_TRIG  = 3'd4
  } wr_op_e;
endpackage

// File: rtl/irq_sync.sv
// Two-flop synchronizer with one history flop for rising-edge detection.
module irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign rise_o  = s2_q & ~prev_q;
endmodule

// File: rtl/irq_chan_cell.sv
// Enable, pending and active state of one channel.
module irq_chan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic level_i,
  input  logic set_en_i,
  input  logic clr_en_i,
  input  logic set_pend_i,
  input  logic clr_pend_i,
  input  logic trig_i,
  input  logic ack_i,
  input  logic exit_i,
  output logic en_o,
  output logic pend_o,
  output logic act_o
);
  logic en_q, pend_q, act_q;
  logic en_d, pend_d, act_d;
  logic en_ce, pend_ce, act_ce;
  logic pend_set, pend_clr, resample;

  always_comb begin
    resample = exit_i & act_q & level_i;
    pend_set = rise_i | resample | set_pend_i | trig_i;
    pend_clr = clr_pend_i | ack_i;
    pend_ce  = pend_set | pend_clr;
    pend_d   = pend_set;
    en_ce    = set_en_i | clr_en_i;
    en_d     = set_en_i;
    act_ce   = ack_i | exit_i;
    act_d    = ack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (pend_ce) pend_q <= pend_d;
      if (act_ce)  act_q  <= act_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign act_o  = act_q;
endmodule

// File: rtl/irq_pick.sv
// Lowest-index selection among candidate channels.
module irq_pick #(
  parameter int NCH = 8,
  parameter int CW  = $clog2(NCH)
) (
  input  logic [NCH-1:0] cand_i,
  output logic [CW-1:0]  sel_o,
  output logic           any_o
);
  always_comb begin
    sel_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand_i[i]) sel_o = CW'(i);
    end
    any_o = |cand_i;
  end
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
  parameter int NCH = 8,
  parameter int CW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] irq_i,
  input  logic           wr_en,
  input  logic [2:0]     wr_op,
  input  logic [NCH-1:0] wr_data,
  input  logic           ack_valid,
  input  logic [CW-1:0]  ack_ch,
  input  logic           exit_strobe,
  output logic [CW-1:0]  sel_ch,
  output logic           req_o
);
  import irq_trk_pkg::*;

  wr_op_e op;
  logic [NCH-1:0] line_lvl, line_rise;
  logic [NCH-1:0] m_set_en, m_clr_en, m_set_pend, m_clr_pend, m_trig, m_ack;
  logic [NCH-1:0] en_q, pend_q, act_q;

  assign op = wr_op_e'(wr_op);

  irq_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(irq_i),
    .level_o(line_lvl), .rise_o(line_rise)
  );

  always_comb begin
    m_set_en   = (wr_en && op == OP_SET_EN)   ? wr_data : '0;
    m_clr_en   = (wr_en && op == OP_CLR_EN)   ? wr_data : '0;
    m_set_pend = (wr_en && op == OP_SET_PEND) ? wr_data : '0;
    m_clr_pend = (wr_en && op == OP_CLR_PEND) ? wr_data : '0;
    for (int i = 0; i < NCH; i++) begin
      m_trig[i] = wr_en && op == OP_SW_TRIG && wr_data[CW-1:0] == CW'(i);
      m_ack[i]  = ack_valid && ack_ch == CW'(i);
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    irq_chan_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .rise_i(line_rise[g]), .level_i(line_lvl[g]),
      .set_en_i(m_set_en[g]), .clr_en_i(m_clr_en[g]),
      .set_pend_i(m_set_pend[g]), .clr_pend_i(m_clr_pend[g]),
      .trig_i(m_trig[g]), .ack_i(m_ack[g]), .exit_i(exit_strobe),
      .en_o(en_q[g]), .pend_o(pend_q[g]), .act_o(act_q[g])
    );
  end

  irq_pick #(.NCH(NCH), .CW(CW)) u_pick (
    .cand_i(pend_q & en_q & ~act_q), .sel_o(sel_ch), .any_o(req_o)
  );
endmodule

// File: rtl/irq_state_tracker_chk.sv
module irq_state_tracker_chk #(
  parameter int NCH = 8,
  parameter int CW  = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [2:0]     wr_op,
  input logic [NCH-1:0] wr_data,
  input logic           ack_valid,
  input logic [CW-1:0]  ack_ch,
  input logic           exit_strobe,
  input logic [CW-1:0]  sel_ch,
  input logic           req_o,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] pend_q,
  input logic [NCH-1:0] act_q
);
  logic [NCH-1:0] clr_mask;
  assign clr_mask = ((wr_en && wr_op == 3'd3) ? wr_data : '0) |
                    (ack_valid ? (NCH'(1) << ack_ch) : '0);

  assert_pend_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~pend_q & $past(pend_q & ~clr_mask)) == '0));

  assert_ack_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> act_q[$past(ack_ch)]);

  assert_one_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_q));

  assert_exit_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_strobe && !ack_valid) |=> (act_q == '0));

  assert_clr_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == 3'd1) |=> ((en_q & $past(wr_data)) == '0));

  assert_sel_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (pend_q[sel_ch] && en_q[sel_ch] && !act_q[sel_ch]));
endmodule

bind irq_state_tracker irq_state_tracker_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
  .ack_valid(ack_valid), .ack_ch(ack_ch), .exit_strobe(exit_strobe),
  .sel_ch(sel_ch), .req_o(req_o), .en_q(en_q), .pend_q(pend_q), .act_q(act_q)
);

// File: tb/sim_irq_state_tracker.sv
`timescale 1ns/1ps
module sim_irq_state_tracker;
  localparam int NCH = 8;
  localparam int CW  = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] irq_i;
  logic wr_en;
  logic [2:0] wr_op;
  logic [NCH-1:0] wr_data;
  logic ack_valid;
  logic [CW-1:0] ack_ch;
  logic exit_strobe;
  logic [CW-1:0] sel_ch;
  logic req_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_state_tracker #(.NCH(NCH), .CW(CW)) u0 (.*);

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string tag, logic exp_req, logic [CW-1:0] exp_sel);
    checks++;
    if (req_o !== exp_req || (exp_req && sel_ch !== exp_sel)) begin
      fails++;
      $display("FAIL %s: req=%0b sel=%0d expected req=%0b sel=%0d",
               tag, req_o, sel_ch, exp_req, exp_sel);
    end
  endtask

  task automatic wr(logic [2:0] op, logic [NCH-1:0] d);
    wr_en = 1'b1; wr_op = op; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ack(int ch);
    ack_valid = 1'b1; ack_ch = CW'(ch);
    step(1);
    ack_valid = 1'b0;
  endtask

  task automatic do_exit();
    exit_strobe = 1'b1;
    step(1);
    exit_strobe = 1'b0;
  endtask

  task automatic t_reset();
    expect_out("R12 reset state", 1'b0, '0);
  endtask

  task automatic t_sync_edge();
    wr(3'd0, 8'h08);
    irq_i[3] = 1'b1;
    step(2);
    expect_out("R11 not pending after two edges", 1'b0, 3'd3);
    step(1);
    expect_out("R11 R1 pending at third edge", 1'b1, 3'd3);
    irq_i[3] = 1'b0;
    step(4);
    expect_out("R2 pending held after line drops", 1'b1, 3'd3);
  endtask

  task automatic t_ack_exit_low();
    ack(3);
    expect_out("R3 ack clears pending, sets active", 1'b0, 3'd3);
    do_exit();
    step(3);
    expect_out("R5 exit with line low does not re-pend", 1'b0, 3'd3);
  endtask

  task automatic t_edge_in_service();
    irq_i[3] = 1'b1; step(3); irq_i[3] = 1'b0; step(3);
    ack(3);
    irq_i[3] = 1'b1; step(2); irq_i[3] = 1'b0; step(4);
    expect_out("R4 active channel not presented", 1'b0, 3'd3);
    do_exit();
    expect_out("R4 R1 edge during service re-pends", 1'b1, 3'd3);
    ack(3); do_exit(); step(1);
    expect_out("R4 cleanup", 1'b0, 3'd3);
  endtask

  task automatic t_level();
    irq_i[3] = 1'b1; step(3);
    expect_out("R1 level line pends", 1'b1, 3'd3);
    ack(3); step(3);
    expect_out("R5 held level makes no new edge", 1'b0, 3'd3);
    do_exit();
    expect_out("R5 R1 exit re-samples high line", 1'b1, 3'd3);
    irq_i[3] = 1'b0; step(3);
    ack(3); do_exit(); step(1);
    expect_out("R5 level cleanup", 1'b0, 3'd3);
  endtask

  task automatic t_enable();
    irq_i[5] = 1'b1; step(2); irq_i[5] = 1'b0; step(4);
    expect_out("R6 disabled pending not presented", 1'b0, 3'd5);
    wr(3'd0, 8'h20);
    expect_out("R6 presented once enabled", 1'b1, 3'd5);
    wr(3'd1, 8'h20);
    expect_out("R6 clear-enable hides channel", 1'b0, 3'd5);
    wr(3'd0, 8'h20);
    expect_out("R6 still pending after re-enable", 1'b1, 3'd5);
    wr(3'd3, 8'h20);
    expect_out("R10 clear-pending", 1'b0, 3'd5);
  endtask

  task automatic t_priority();
    wr(3'd0, 8'hFF);
    wr(3'd2, 8'h44);
    expect_out("R7 R9 lowest of set-pending mask", 1'b1, 3'd2);
    wr(3'd3, 8'h04);
    expect_out("R10 R9 next channel after clear", 1'b1, 3'd6);
    ack(6);
    expect_out("R9 none presentable while 6 active", 1'b0, 3'd6);
    do_exit();
    expect_out("R7 software pend leaves no re-pend", 1'b0, 3'd6);
  endtask

  task automatic t_swtrig();
    wr(3'd4, 8'h07);
    expect_out("R8 software trigger channel 7", 1'b1, 3'd7);
    ack(7); do_exit();
    expect_out("R8 cleanup", 1'b0, 3'd7);
  endtask

  task automatic t_zero_writes();
    wr(3'd2, 8'h00);
    expect_out("R12 zero set-pending no effect", 1'b0, 3'd0);
    wr(3'd2, 8'h10);
    wr(3'd3, 8'h00);
    expect_out("R12 zero clear-pending no effect", 1'b1, 3'd4);
    wr(3'd1, 8'h00);
    expect_out("R12 zero clear-enable no effect", 1'b1, 3'd4);
    wr(3'd3, 8'h10);
    expect_out("R10 cleanup", 1'b0, 3'd4);
  endtask

  task automatic t_set_wins();
    irq_i[0] = 1'b1;
    step(2);
    wr(3'd3, 8'h01);
    expect_out("R10 edge set wins over clear", 1'b1, 3'd0);
    irq_i[0] = 1'b0; step(3);
    ack(0); do_exit(); step(1);
    expect_out("R10 collision cleanup", 1'b0, 3'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_i = '0; wr_en = 1'b0; wr_op = '0; wr_data = '0;
    ack_valid = 1'b0; ack_ch = '0; exit_strobe = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_sync_edge();
    t_ack_exit_low();
    t_edge_in_service();
    t_level();
    t_enable();
    t_priority();
    t_swtrig();
    t_zero_writes();
    t_set_wins();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule